// File: doc/BRIEF.md
# Effective-Address Generator with Register Update

This block turns a decoded operand specifier into a 32-bit memory address. It takes a three-bit mode field, a three-bit register field, an operand size and up to 32 bits of extension data. It reads the eight address registers and eight data registers as flat vectors. The address is produced combinationally in the same cycle as the request. For the auto-increment and auto-decrement forms, the block also emits a one-cycle write-back of the updated address register. The register file that stores and writes the registers sits outside the block.

An instruction can ask for the same operand address more than once. The first request that yields a memory address stores that address. Later requests in the same instruction return the stored value, with zero cycle cost and no second register update. Pulsing the clear input at the start of each instruction discards the stored value. A clear given together with a request counts as the first request of a new instruction.

Operand specifiers that name a register directly, or that carry immediate data, have no memory address. For these the block raises a flag instead. Each memory form reports its cycle cost from a parameter table.

Top module: `ea_gen`

## Requirements
- R1: Mode 2 (register indirect) returns address register `reg_i` unchanged and requests no write-back.
- R2: Mode 3 (post-increment) returns the old register value and writes back old+step. The size encoding is 0 = byte, 1 = word, 2 = long, and the step is 1, 2 or 4 bytes.
- R3: When register 7 is used with byte size in mode 3 or mode 4, the step is 2 instead of 1.
- R4: Mode 4 (pre-decrement) returns old−step and writes that same value back to register `reg_i`.
- R5: Mode 5 returns the address register plus `ext_i[15:0]` sign-extended, modulo 2^32.
- R6: Mode 6 returns base + sign-extended `ext_i[7:0]` + index, where `ext_i[15:0]` is decoded as follows. Bit 15 picks an address (1) or data (0) index register. Bits 14:12 give its number. Bit 11 picks long (1) or word (0); a word index is sign-extended from its low 16 bits.
- R7: Mode 7 with register 0 returns `ext_i[15:0]` sign-extended to 32 bits. Mode 7 with register 1 returns `ext_i` as it is.
- R8: Mode 7 with register 2 returns `pc_i` plus sign-extended `ext_i[15:0]`. Mode 7 with register 3 returns the same sum as R6 with `pc_i` as the base.
- R9: For modes 0 and 1, and for mode 7 with register 4 to 7, a request raises `not_mem_o`. In that case `valid_o` stays low, there is no write-back and the cost is 0.
- R10: A request that computes a fresh memory address reports the cost parameter of its form on `cost_o`. `cost_o` is 0 when there is no request.
- R11: After a memory address has been stored, a request without clear returns the stored address with `valid_o` high, cost 0 and no write-back, whatever the mode inputs are.
- R12: A clear discards the stored address. A request that comes after the clear, or in the same cycle as it, computes afresh and performs its write-back.
- R13: Reset empties the stored address, so the first request after reset computes afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Instruction start; discards the stored address |
| req_i | input | 1 | Address request |
| mode_i | input | 3 | Mode field |
| reg_i | input | 3 | Register field (sub-mode selector in mode 7) |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| ext_i | input | 32 | Extension data (displacement, index word, absolute value) |
| pc_i | input | 32 | Captured program-counter base |
| areg_i | input | 256 | Address registers, register n at bits n*32 +: 32 |
| dreg_i | input | 256 | Data registers, register n at bits n*32 +: 32 |
| valid_o | output | 1 | A memory address is presented on addr_o |
| not_mem_o | output | 1 | The requested operand has no memory address |
| addr_o | output | 32 | Effective address |
| cost_o | output | 8 | Cycle cost of this computation |
| wb_en_o | output | 1 | Write wb_data_o into address register wb_idx_o |
| wb_idx_o | output | 3 | Write-back register number |
| wb_data_o | output | 32 | Updated register value |

## Verification
The bench checks that register 7 steps by 2 for byte size in both auto modes. A design that forgets this misaligns the stack pointer by one byte. It drives index words with negative low halves, so a word index that is not sign-extended would be off by 65536. It also drives base values next to 2^32, which exposes any wraparound error. It sends repeated requests with changed mode inputs: a design that recomputes would write the register a second time and drift the pointer. It also covers clear and request in the same cycle, where a design that honours the stale value would skip the new instruction's update.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [3:0] {
        K_DREG, K_AREG, K_IND, K_POST, K_PRE, K_DISP, K_IDX,
        K_ABSW, K_ABSL, K_PCD, K_PCX, K_IMM, K_BAD
    } ea_kind_e;

    // Index extension word; field positions are decoded by ea_index.
    typedef struct packed {
        logic       idx_is_addr;
        logic [2:0] idx_num;
        logic       idx_long;
        logic [2:0] spare;
        logic [7:0] disp;
    } brief_t;

    function automatic ea_kind_e decode_kind(input logic [2:0] mode, input logic [2:0] rnum);
        ea_kind_e k;
        case (mode)
            3'd0: k = K_DREG;
            3'd1: k = K_AREG;
            3'd2: k = K_IND;
            3'd3: k = K_POST;
            3'd4: k = K_PRE;
            3'd5: k = K_DISP;
            3'd6: k = K_IDX;
            default: begin
                case (rnum)
                    3'd0:    k = K_ABSW;
                    3'd1:    k = K_ABSL;
                    3'd2:    k = K_PCD;
                    3'd3:    k = K_PCX;
                    3'd4:    k = K_IMM;
                    default: k = K_BAD;
                endcase
            end
        endcase
        return k;
    endfunction

    function automatic logic in_memory(input ea_kind_e k);
        return !(k == K_DREG || k == K_AREG || k == K_IMM || k == K_BAD);
    endfunction

endpackage

// File: rtl/ea_step.sv
module ea_step
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  size_e         size_i,
    input  logic          stack_i,
    output logic [AW-1:0] step_o
);
    always_comb begin
        case (size_i)
            SZ_BYTE: step_o = stack_i ? AW'(2) : AW'(1);
            SZ_WORD: step_o = AW'(2);
            default: step_o = AW'(4);
        endcase
    end
endmodule

// File: rtl/ea_index.sv
module ea_index
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  brief_t             brief_i,
    input  logic [NREG*AW-1:0] areg_i,
    input  logic [NREG*AW-1:0] dreg_i,
    output logic [AW-1:0]      idx_o
);
    logic [AW-1:0] a_arr [NREG];
    logic [AW-1:0] d_arr [NREG];
    logic [AW-1:0] raw;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign a_arr[g] = areg_i[g*AW +: AW];
        assign d_arr[g] = dreg_i[g*AW +: AW];
    end

    always_comb begin
        raw   = brief_i.idx_is_addr ? a_arr[brief_i.idx_num] : d_arr[brief_i.idx_num];
        idx_o = brief_i.idx_long ? raw : {{(AW-16){raw[15]}}, raw[15:0]};
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  ea_kind_e           kind_i,
    input  logic [2:0]         rnum_i,
    input  size_e              size_i,
    input  logic [AW-1:0]      ext_i,
    input  logic [AW-1:0]      pc_i,
    input  logic [NREG*AW-1:0] areg_i,
    input  logic [NREG*AW-1:0] dreg_i,
    output logic [AW-1:0]      addr_o,
    output logic               wb_o,
    output logic [AW-1:0]      wb_data_o
);
    logic [AW-1:0] a_arr [NREG];
    logic [AW-1:0] base, step, idx, sx16, sx8;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign a_arr[g] = areg_i[g*AW +: AW];
    end

    assign base = a_arr[rnum_i];
    assign sx16 = {{(AW-16){ext_i[15]}}, ext_i[15:0]};
    assign sx8  = {{(AW-8){ext_i[7]}}, ext_i[7:0]};

    ea_step #(.AW(AW)) u_step (
        .size_i (size_i),
        .stack_i(rnum_i == 3'(NREG-1)),
        .step_o (step)
    );

    ea_index #(.AW(AW), .NREG(NREG)) u_index (
        .brief_i(brief_t'(ext_i[15:0])),
        .areg_i (areg_i),
        .dreg_i (dreg_i),
        .idx_o  (idx)
    );

    always_comb begin
        addr_o    = '0;
        wb_o      = 1'b0;
        wb_data_o = base;
        case (kind_i)
            K_IND:  addr_o = base;
            K_POST: begin
                addr_o    = base;
                wb_o      = 1'b1;
                wb_data_o = base + step;
            end
            K_PRE: begin
                addr_o    = base - step;
                wb_o      = 1'b1;
                wb_data_o = base - step;
            end
            K_DISP: addr_o = base + sx16;
            K_IDX:  addr_o = base + sx8 + idx;
            K_ABSW: addr_o = sx16;
            K_ABSL: addr_o = ext_i;
            K_PCD:  addr_o = pc_i + sx16;
            K_PCX:  addr_o = pc_i + sx8 + idx;
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NREG      = 8,
    parameter int CW        = 8,
    parameter int COST_IND  = 4,
    parameter int COST_POST = 4,
    parameter int COST_PRE  = 6,
    parameter int COST_DISP = 8,
    parameter int COST_IDX  = 10,
    parameter int COST_ABSW = 8,
    parameter int COST_ABSL = 12,
    parameter int COST_PCD  = 8,
    parameter int COST_PCX  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               req_i,
    input  logic [2:0]         mode_i,
    input  logic [2:0]         reg_i,
    input  logic [1:0]         size_i,
    input  logic [AW-1:0]      ext_i,
    input  logic [AW-1:0]      pc_i,
    input  logic [NREG*AW-1:0] areg_i,
    input  logic [NREG*AW-1:0] dreg_i,
    output logic               valid_o,
    output logic               not_mem_o,
    output logic [AW-1:0]      addr_o,
    output logic [CW-1:0]      cost_o,
    output logic               wb_en_o,
    output logic [2:0]         wb_idx_o,
    output logic [AW-1:0]      wb_data_o
);
    ea_kind_e      kind;
    logic          mem, hit, fresh, calc_wb;
    logic [AW-1:0] calc_addr;
    logic [CW-1:0] mode_cost;

    logic          held_q;
    logic [AW-1:0] held_addr_q;

    assign kind = decode_kind(mode_i, reg_i);
    assign mem  = in_memory(kind);
    assign hit  = held_q && !clr_i;
    assign fresh = req_i && !hit;

    ea_calc #(.AW(AW), .NREG(NREG)) u_calc (
        .kind_i   (kind),
        .rnum_i   (reg_i),
        .size_i   (size_e'(size_i)),
        .ext_i    (ext_i),
        .pc_i     (pc_i),
        .areg_i   (areg_i),
        .dreg_i   (dreg_i),
        .addr_o   (calc_addr),
        .wb_o     (calc_wb),
        .wb_data_o(wb_data_o)
    );

    always_comb begin
        case (kind)
            K_IND:   mode_cost = CW'(COST_IND);
            K_POST:  mode_cost = CW'(COST_POST);
            K_PRE:   mode_cost = CW'(COST_PRE);
            K_DISP:  mode_cost = CW'(COST_DISP);
            K_IDX:   mode_cost = CW'(COST_IDX);
            K_ABSW:  mode_cost = CW'(COST_ABSW);
            K_ABSL:  mode_cost = CW'(COST_ABSL);
            K_PCD:   mode_cost = CW'(COST_PCD);
            K_PCX:   mode_cost = CW'(COST_PCX);
            default: mode_cost = '0;
        endcase
    end

    assign valid_o   = req_i && (hit || mem);
    assign not_mem_o = fresh && !mem;
    assign addr_o    = hit ? held_addr_q : (mem ? calc_addr : '0);
    assign cost_o    = fresh ? mode_cost : '0;
    assign wb_en_o   = fresh && calc_wb;
    assign wb_idx_o  = reg_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= 1'b0;
            held_addr_q <= '0;
        end else if (fresh && mem) begin
            held_q      <= 1'b1;
            held_addr_q <= calc_addr;
        end else if (clr_i) begin
            held_q      <= 1'b0;
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          clr_i,
    input logic          req_i,
    input logic [2:0]    mode_i,
    input logic [2:0]    reg_i,
    input logic          valid_o,
    input logic          not_mem_o,
    input logic [AW-1:0] addr_o,
    input logic [CW-1:0] cost_o,
    input logic          wb_en_o,
    input logic [2:0]    wb_idx_o
);
    assert_indirect_no_wb_R1: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 3'd2) |-> !wb_en_o);

    assert_wb_only_auto_R2: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (req_i && (mode_i == 3'd3 || mode_i == 3'd4) && wb_idx_o == reg_i));

    assert_no_mem_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        not_mem_o |-> (!valid_o && !wb_en_o && cost_o == '0));

    assert_idle_no_cost_R10: assert property (@(posedge clk) disable iff (rst)
        !req_i |-> (cost_o == '0 && !valid_o && !wb_en_o));

    assert_repeat_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (req_i && valid_o) |=>
            (!(req_i && !clr_i) || (addr_o == $past(addr_o) && !wb_en_o && cost_o == '0)));

    assert_clear_fresh_R12: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !req_i) |=> (!(req_i && mode_i == 3'd3) || wb_en_o));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .req_i    (req_i),
    .mode_i   (mode_i),
    .reg_i    (reg_i),
    .valid_o  (valid_o),
    .not_mem_o(not_mem_o),
    .addr_o   (addr_o),
    .cost_o   (cost_o),
    .wb_en_o  (wb_en_o),
    .wb_idx_o (wb_idx_o)
);

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst, clr_i, req_i;
    logic [2:0]   mode_i, reg_i;
    logic [1:0]   size_i;
    logic [31:0]  ext_i, pc_i;
    logic [255:0] areg_i, dreg_i;
    logic         valid_o, not_mem_o, wb_en_o;
    logic [31:0]  addr_o, wb_data_o;
    logic [7:0]   cost_o;
    logic [2:0]   wb_idx_o;

    logic [31:0] ar [8];
    logic [31:0] dr [8];
    for (genvar g = 0; g < 8; g++) begin : g_flat
        assign areg_i[g*32 +: 32] = ar[g];
        assign dreg_i[g*32 +: 32] = dr[g];
    end

    ea_gen u_ea_gen (
        .clk(clk), .rst(rst), .clr_i(clr_i), .req_i(req_i), .mode_i(mode_i),
        .reg_i(reg_i), .size_i(size_i), .ext_i(ext_i), .pc_i(pc_i),
        .areg_i(areg_i), .dreg_i(dreg_i), .valid_o(valid_o), .not_mem_o(not_mem_o),
        .addr_o(addr_o), .cost_o(cost_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
        .wb_data_o(wb_data_o)
    );

    int errors = 0;
    int checks = 0;
    bit          m_held = 1'b0;
    logic [31:0] m_addr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int cost_of(input logic [2:0] md, input logic [2:0] rg);
        case (md)
            3'd2: return 4;
            3'd3: return 4;
            3'd4: return 6;
            3'd5: return 8;
            3'd6: return 10;
            3'd7: begin
                if (rg == 0) return 8;
                if (rg == 1) return 12;
                if (rg == 2) return 8;
                if (rg == 3) return 10;
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    task automatic step(input bit c, input bit r, input logic [2:0] md, input logic [2:0] rg,
                        input logic [1:0] sz, input logic [31:0] ext, input string tg);
        bit nm, hit, e_valid, e_nm, e_wb;
        logic [31:0] e_addr, e_wbd, stp, idx, rawi, s16, s8, base;
        int e_cost;
        string tag;
        clr_i = c; req_i = r; mode_i = md; reg_i = rg; size_i = sz; ext_i = ext;
        @(negedge clk);
        nm   = (md < 3'd2) || (md == 3'd7 && rg > 3'd3);
        hit  = m_held && !c;
        base = ar[rg];
        s16  = {{16{ext[15]}}, ext[15:0]};
        s8   = {{24{ext[7]}}, ext[7:0]};
        stp  = (sz == 2'd0) ? ((rg == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1 ? 32'd2 : 32'd4);
        rawi = ext[15] ? ar[ext[14:12]] : dr[ext[14:12]];
        idx  = ext[11] ? rawi : {{16{rawi[15]}}, rawi[15:0]};
        e_wb = 1'b0; e_wbd = '0; e_addr = '0;
        case (md)
            3'd2: e_addr = base;
            3'd3: begin e_addr = base; e_wb = 1'b1; e_wbd = base + stp; end
            3'd4: begin e_addr = base - stp; e_wb = 1'b1; e_wbd = e_addr; end
            3'd5: e_addr = base + s16;
            3'd6: e_addr = base + s8 + idx;
            3'd7: begin
                if (rg == 0) e_addr = s16;
                else if (rg == 1) e_addr = ext;
                else if (rg == 2) e_addr = pc_i + s16;
                else if (rg == 3) e_addr = pc_i + s8 + idx;
            end
            default: ;
        endcase
        e_cost = cost_of(md, rg);
        if (hit) begin e_addr = m_addr; e_wb = 1'b0; e_cost = 0; end
        if (!r) begin e_wb = 1'b0; e_cost = 0; end
        e_valid = r && (hit || !nm);
        e_nm    = r && !hit && nm;
        if (tg != "") tag = tg;
        else if (hit) tag = "R11";
        else if (nm) tag = "R9";
        else if (md == 3'd2) tag = "R1";
        else if ((md == 3'd3 || md == 3'd4) && rg == 3'd7 && sz == 2'd0) tag = "R3";
        else if (md == 3'd3) tag = "R2";
        else if (md == 3'd4) tag = "R4";
        else if (md == 3'd5) tag = "R5";
        else if (md == 3'd6) tag = "R6";
        else if (rg < 3'd2) tag = "R7";
        else tag = "R8";
        chk(valid_o == e_valid, tag, "valid", 32'(valid_o), 32'(e_valid));
        chk(not_mem_o == e_nm, tag, "not_mem", 32'(not_mem_o), 32'(e_nm));
        chk(wb_en_o == e_wb, tag, "wb_en", 32'(wb_en_o), 32'(e_wb));
        chk(cost_o == 8'(e_cost), (r && !hit && !nm) ? "R10" : tag, "cost",
            32'(cost_o), 32'(e_cost));
        if (e_valid) chk(addr_o == e_addr, tag, "addr", addr_o, e_addr);
        if (e_wb) begin
            chk(wb_idx_o == rg, tag, "wb_idx", 32'(wb_idx_o), 32'(rg));
            chk(wb_data_o == e_wbd, tag, "wb_data", wb_data_o, e_wbd);
        end
        @(posedge clk);
        #1;
        if (r && !hit && !nm) begin m_held = 1'b1; m_addr = e_addr; end
        else if (c) m_held = 1'b0;
        if (e_wb) ar[rg] = e_wbd;
    endtask

    task automatic instr(input logic [2:0] md, input logic [2:0] rg, input logic [1:0] sz,
                         input logic [31:0] ext, input int reps);
        step(1'b1, 1'b1, md, rg, sz, ext, "");
        for (int i = 0; i < reps; i++) step(1'b0, 1'b1, md, rg, sz, ext, "");
        step(1'b0, 1'b0, md, rg, sz, ext, "");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            ar[i] = 32'h1000_0000 + 32'(i) * 32'h100;
            dr[i] = 32'h0000_0040 * 32'(i + 1);
        end
        ar[2] = 32'hFFFF_FFFE;
        ar[7] = 32'h0000_2000;
        dr[3] = 32'h0001_8000;
        dr[5] = 32'h7FFF_0010;
        pc_i  = 32'h0000_0100;
        rst = 1'b1; clr_i = 1'b0; req_i = 1'b1; mode_i = 3'd3; reg_i = 3'd1;
        size_i = 2'd2; ext_i = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(1'b0, 1'b1, 3'd3, 3'd1, 2'd2, 32'd0, "R13");
        step(1'b0, 1'b0, 3'd3, 3'd1, 2'd2, 32'd0, "R10");

        instr(3'd2, 3'd2, 2'd1, 32'd0, 1);
        instr(3'd3, 3'd1, 2'd0, 32'd0, 1);
        instr(3'd3, 3'd1, 2'd1, 32'd0, 0);
        instr(3'd3, 3'd2, 2'd2, 32'd0, 1);
        instr(3'd3, 3'd7, 2'd0, 32'd0, 2);
        instr(3'd4, 3'd7, 2'd0, 32'd0, 1);
        instr(3'd4, 3'd0, 2'd0, 32'd0, 0);
        instr(3'd4, 3'd3, 2'd2, 32'd0, 0);
        instr(3'd5, 3'd4, 2'd1, 32'h0000_FFF0, 0);
        instr(3'd5, 3'd2, 2'd1, 32'h0000_0004, 0);
        instr(3'd6, 3'd1, 2'd1, 32'h0000_30FE, 0);
        instr(3'd6, 3'd5, 2'd1, 32'h0000_D810, 0);
        instr(3'd6, 3'd0, 2'd1, 32'h0000_5805, 0);
        instr(3'd7, 3'd0, 2'd1, 32'h0000_8000, 0);
        instr(3'd7, 3'd1, 2'd1, 32'h1234_5678, 0);
        instr(3'd7, 3'd2, 2'd1, 32'h0000_FFFE, 0);
        instr(3'd7, 3'd3, 2'd1, 32'h0000_9805, 0);
        instr(3'd7, 3'd4, 2'd2, 32'hDEAD_BEEF, 0);
        instr(3'd0, 3'd3, 2'd2, 32'd0, 0);
        instr(3'd1, 3'd6, 2'd2, 32'd0, 0);
        instr(3'd7, 3'd6, 2'd2, 32'd0, 0);

        // repeat with altered mode inputs must still return the stored value
        step(1'b1, 1'b1, 3'd4, 3'd6, 2'd2, 32'd0, "R4");
        step(1'b0, 1'b1, 3'd3, 3'd6, 2'd1, 32'd0, "R11");
        step(1'b0, 1'b1, 3'd0, 3'd1, 2'd1, 32'd0, "R11");
        // clear alone, then request: fresh
        step(1'b1, 1'b0, 3'd3, 3'd5, 2'd1, 32'd0, "R12");
        step(1'b0, 1'b1, 3'd3, 3'd5, 2'd1, 32'd0, "R12");
        // clear with request in same cycle: fresh
        step(1'b1, 1'b1, 3'd3, 3'd5, 2'd2, 32'd0, "R12");
        step(1'b0, 1'b1, 3'd3, 3'd5, 2'd2, 32'd0, "R11");

        for (int n = 0; n < 400; n++) begin
            step(($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0),
                 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 2'($urandom_range(0, 2)), $urandom, "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule